// File: doc/BRIEF.md
# CPU Mode and Bus Lock Controller

This block holds the control flags of a processor status register: a sticky extended-mode flag, a long-word operand-size flag, the master interrupt enable, a two-bit interrupt-mode field and a bus-lock flag. The instruction decoder drives one-cycle command strobes. The flags change on the clock edge that samples a strobe. The rest of the core reads the flags directly from the outputs.

The lock flag also controls an external bus request/grant handshake. While the lock flag is clear, a request is granted one clock after it is sampled. The grant is withdrawn one clock after the request falls. While the lock flag is set, no new grant is issued. A grant that was already active when the lock was taken stays active until the requester releases it.

Top module: `cpu_mode_lock_ctrl`

## Requirements
- R1: While `rstN` is low, every flag output is 0, `intMode` is 2'b00 and `busGrant` is 0.
- R2: A set-mode strobe with `modeSel` = 2'b00 sets `extMode`. A reset-mode strobe with `modeSel` = 2'b00 has no effect, even in the same cycle. Only `rstN` clears `extMode`.
- R3: A set-mode strobe with `modeSel` = 2'b01 sets `longWord`, and a reset-mode strobe with `modeSel` = 2'b01 clears it. If both strobes arrive in the same cycle, the flag is cleared.
- R4: `eiStb` sets `intEnable` and `diStb` clears it. If both arrive in the same cycle, the flag is cleared.
- R5: `imStb` loads `imVal` into `intMode`. The code 2'b00 selects mode 0, 2'b01 mode 1, 2'b10 mode 2 and 2'b11 mode 3.
- R6: A set-mode strobe with `modeSel` = 2'b10 sets `busLock`, and a reset-mode strobe with `modeSel` = 2'b10 clears it. If both strobes arrive in the same cycle, the flag is cleared.
- R7: While `busLock` is clear, `busGrant` rises one clock after `busReq` is sampled high. It falls one clock after `busReq` is sampled low.
- R8: While `busLock` is set and `busGrant` is low, `busGrant` stays low regardless of `busReq`.
- R9: If `busLock` becomes set while `busGrant` is high, the grant stays high while `busReq` stays high. It falls one clock after `busReq` drops.
- R10: Set-mode and reset-mode strobes with `modeSel` = 2'b11 change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| setModeStb | input | 1 | Set-mode command strobe |
| resetModeStb | input | 1 | Reset-mode command strobe |
| modeSel | input | 2 | Target flag of the mode strobes: 00 extended, 01 long-word, 10 lock, 11 none |
| eiStb | input | 1 | Interrupt-enable command strobe |
| diStb | input | 1 | Interrupt-disable command strobe |
| imStb | input | 1 | Interrupt-mode load strobe |
| imVal | input | 2 | Interrupt mode value loaded by `imStb` |
| busReq | input | 1 | External bus request |
| extMode | output | 1 | Extended-mode flag |
| longWord | output | 1 | Long-word mode flag |
| intEnable | output | 1 | Master interrupt enable |
| intMode | output | 2 | Interrupt mode field |
| busLock | output | 1 | Bus lock flag |
| busGrant | output | 1 | External bus grant |

## Verification
Random strobes are sent with every `modeSel` code, including colliding set/clear pairs. Alongside them, `busReq` toggles with random hold times. This separates the clear-wins priority from plain set or clear behaviour, and separates the sticky extended flag from the clearable ones.

Directed sequences cover three cases that random stimulus reaches only rarely:
- a request raised while locked, which must never be granted;
- a lock taken during an active grant, which must hold the grant until release;
- a strobe with the unused `modeSel` code, which must leave every output unchanged.

// File: rtl/cpu_mode_pkg.sv
package cpu_mode_pkg;
  localparam int IM_W  = 2;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_EXT  = 2'b00,
    SEL_LONG = 2'b01,
    SEL_LOCK = 2'b10,
    SEL_NONE = 2'b11
  } modeSel_e;

  typedef struct packed {
    logic            setExt;
    logic            setLong;
    logic            clrLong;
    logic            setLock;
    logic            clrLock;
    logic            setIe;
    logic            clrIe;
    logic            loadIm;
    logic [IM_W-1:0] imVal;
  } ctlStb_t;
endpackage

// File: rtl/mode_cmd_ctrl.sv
module mode_cmd_ctrl
  import cpu_mode_pkg::*;
(
  input  logic             setModeStb,
  input  logic             resetModeStb,
  input  logic [SEL_W-1:0] modeSel,
  input  logic             eiStb,
  input  logic             diStb,
  input  logic             imStb,
  input  logic [IM_W-1:0]  imVal,
  output ctlStb_t          ctl
);
  modeSel_e selDec;

  always_comb begin
    selDec = modeSel_e'(modeSel);
    ctl = '0;
    unique case (selDec)
      // The reset-mode strobe aimed at the extended flag is dropped here (R2).
      SEL_EXT:  ctl.setExt = setModeStb;
      SEL_LONG: begin
        ctl.setLong = setModeStb;
        ctl.clrLong = resetModeStb;
      end
      SEL_LOCK: begin
        ctl.setLock = setModeStb;
        ctl.clrLock = resetModeStb;
      end
      default: ; // SEL_NONE: no target (R10)
    endcase
    ctl.setIe  = eiStb;
    ctl.clrIe  = diStb;
    ctl.loadIm = imStb;
    ctl.imVal  = imVal;
  end
endmodule

// File: rtl/mode_flag_dp.sv
module mode_flag_dp
  import cpu_mode_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  ctlStb_t         ctl,
  output logic            extMode,
  output logic            longWord,
  output logic            intEnable,
  output logic [IM_W-1:0] intMode,
  output logic            busLock
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extMode   <= 1'b0;
      longWord  <= 1'b0;
      intEnable <= 1'b0;
      intMode   <= '0;
      busLock   <= 1'b0;
    end else begin
      if (ctl.setExt) extMode <= 1'b1;
      if (ctl.clrLong)      longWord <= 1'b0;
      else if (ctl.setLong) longWord <= 1'b1;
      if (ctl.clrIe)        intEnable <= 1'b0;
      else if (ctl.setIe)   intEnable <= 1'b1;
      if (ctl.loadIm)       intMode <= ctl.imVal;
      if (ctl.clrLock)      busLock <= 1'b0;
      else if (ctl.setLock) busLock <= 1'b1;
    end
  end

  assert_ext_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(extMode));
  assert_long_clr_wins_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrLong |=> !longWord);
  assert_ie_clr_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrIe |=> !intEnable);
  assert_im_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadIm |=> (intMode == $past(ctl.imVal)));
  assert_lock_clr_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrLock |=> !busLock);
endmodule

// File: rtl/bus_grant_arb.sv
module bus_grant_arb (
  input  logic clk,
  input  logic rstN,
  input  logic busReq,
  input  logic busLock,
  output logic busGrant
);
  logic grantNext;

  always_comb begin
    if (busGrant) grantNext = busReq;             // hold until released
    else          grantNext = busReq && !busLock; // new grants only when unlocked
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busGrant <= 1'b0;
    else       busGrant <= grantNext;
  end

  assert_grant_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busLock && !busGrant) |=> busGrant);
  assert_grant_fall_R7: assert property (@(posedge clk) disable iff (!rstN)
    !busReq |=> !busGrant);
  assert_locked_no_grant_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busLock && !busGrant) |=> !busGrant);
  assert_grant_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busGrant && busReq) |=> busGrant);
endmodule

// File: rtl/cpu_mode_lock_ctrl.sv
module cpu_mode_lock_ctrl
  import cpu_mode_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             setModeStb,
  input  logic             resetModeStb,
  input  logic [SEL_W-1:0] modeSel,
  input  logic             eiStb,
  input  logic             diStb,
  input  logic             imStb,
  input  logic [IM_W-1:0]  imVal,
  input  logic             busReq,
  output logic             extMode,
  output logic             longWord,
  output logic             intEnable,
  output logic [IM_W-1:0]  intMode,
  output logic             busLock,
  output logic             busGrant
);
  ctlStb_t ctl;

  mode_cmd_ctrl uCtrl (
    .setModeStb(setModeStb), .resetModeStb(resetModeStb), .modeSel(modeSel),
    .eiStb(eiStb), .diStb(diStb), .imStb(imStb), .imVal(imVal), .ctl(ctl)
  );

  mode_flag_dp uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .extMode(extMode), .longWord(longWord),
    .intEnable(intEnable), .intMode(intMode), .busLock(busLock)
  );

  bus_grant_arb uArb (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busLock(busLock), .busGrant(busGrant)
  );

  assert_reset_state_R1: assert property (@(posedge clk)
    !rstN |-> (!extMode && !longWord && !intEnable && intMode == '0 && !busLock && !busGrant));
endmodule

// File: tb/cpu_mode_lock_ctrl_test.sv
module cpu_mode_lock_ctrl_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic setModeStb = 0, resetModeStb = 0, eiStb = 0, diStb = 0, imStb = 0, busReq = 0;
  logic [1:0] modeSel = 0, imVal = 0;
  logic extMode, longWord, intEnable, busLock, busGrant;
  logic [1:0] intMode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model of the expected state
  logic mXm = 0, mLw = 0, mIe = 0, mLck = 0, mGnt = 0;
  logic [1:0] mIm = 0;

  always #10 clk = ~clk; // 50 MHz

  cpu_mode_lock_ctrl uut (
    .clk(clk), .rstN(rstN), .setModeStb(setModeStb), .resetModeStb(resetModeStb),
    .modeSel(modeSel), .eiStb(eiStb), .diStb(diStb), .imStb(imStb), .imVal(imVal),
    .busReq(busReq), .extMode(extMode), .longWord(longWord), .intEnable(intEnable),
    .intMode(intMode), .busLock(busLock), .busGrant(busGrant)
  );

  task automatic check(input string tag, input string name, input logic [1:0] act,
                       input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, name, act, exp);
    end
  endtask

  function automatic logic nextFlag(input logic cur, input logic set, input logic clr);
    return clr ? 1'b0 : (set ? 1'b1 : cur);
  endfunction

  task automatic modelStep();
    logic oldLck;
    oldLck = mLck;
    if (setModeStb && modeSel == 2'b00) mXm = 1'b1;
    mLw  = nextFlag(mLw,  setModeStb && modeSel == 2'b01, resetModeStb && modeSel == 2'b01);
    mLck = nextFlag(mLck, setModeStb && modeSel == 2'b10, resetModeStb && modeSel == 2'b10);
    mIe  = nextFlag(mIe, eiStb, diStb);
    if (imStb) mIm = imVal;
    mGnt = mGnt ? busReq : (busReq && !oldLck);
  endtask

  task automatic compareAll();
    check("R2", "extMode",   {1'b0, extMode},   {1'b0, mXm});
    check("R3", "longWord",  {1'b0, longWord},  {1'b0, mLw});
    check("R4", "intEnable", {1'b0, intEnable}, {1'b0, mIe});
    check("R5", "intMode",   intMode,           mIm);
    check("R6", "busLock",   {1'b0, busLock},   {1'b0, mLck});
    check("R7", "busGrant",  {1'b0, busGrant},  {1'b0, mGnt});
  endtask

  // Called at a negedge: drive, clock, update model, compare at the next negedge
  task automatic step(input logic s, input logic r, input logic [1:0] sel, input logic ei,
                      input logic di, input logic im, input logic [1:0] iv, input logic req);
    setModeStb = s; resetModeStb = r; modeSel = sel; eiStb = ei; diStb = di;
    imStb = im; imVal = iv; busReq = req;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (2) @(negedge clk);
    // R1: reset state
    check("R1", "extMode",   {1'b0, extMode},   2'd0);
    check("R1", "longWord",  {1'b0, longWord},  2'd0);
    check("R1", "intEnable", {1'b0, intEnable}, 2'd0);
    check("R1", "intMode",   intMode,           2'd0);
    check("R1", "busLock",   {1'b0, busLock},   2'd0);
    check("R1", "busGrant",  {1'b0, busGrant},  2'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R5: every interrupt-mode code
    for (int m = 0; m < 4; m++) step(0, 0, 2'b11, 0, 0, 1, 2'(m), 0);
    // R3, R4, R6: simultaneous set and clear, clear wins
    step(1, 0, 2'b01, 1, 0, 0, 0, 0);
    step(1, 1, 2'b01, 1, 1, 0, 0, 0);
    check("R3", "longWord collision", {1'b0, longWord}, 2'd0);
    check("R4", "intEnable collision", {1'b0, intEnable}, 2'd0);
    step(1, 1, 2'b10, 0, 0, 0, 0, 0);
    check("R6", "busLock collision", {1'b0, busLock}, 2'd0);

    // R7: grant latency while unlocked
    step(0, 0, 2'b11, 0, 0, 0, 0, 1);
    check("R7", "grant after request", {1'b0, busGrant}, 2'd1);
    step(0, 0, 2'b11, 0, 0, 0, 0, 0);
    check("R7", "grant after release", {1'b0, busGrant}, 2'd0);

    // R8: locked, a request is never granted
    step(1, 0, 2'b10, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      step(0, 0, 2'b11, 0, 0, 0, 0, 1);
      check("R8", "locked grant", {1'b0, busGrant}, 2'd0);
    end
    step(0, 1, 2'b10, 0, 0, 0, 0, 0);

    // R9: lock taken during an active grant
    step(0, 0, 2'b11, 0, 0, 0, 0, 1);
    step(1, 0, 2'b10, 0, 0, 0, 0, 1);
    step(0, 0, 2'b11, 0, 0, 0, 0, 1);
    check("R9", "held grant", {1'b0, busGrant}, 2'd1);
    step(0, 0, 2'b11, 0, 0, 0, 0, 0);
    check("R9", "released grant", {1'b0, busGrant}, 2'd0);
    step(0, 1, 2'b10, 0, 0, 0, 0, 0);

    // R10: unused selector code
    step(1, 0, 2'b01, 0, 0, 0, 0, 0);
    step(1, 1, 2'b11, 0, 0, 0, 0, 0);
    check("R10", "longWord sel11", {1'b0, longWord}, 2'd1);
    check("R10", "extMode sel11", {1'b0, extMode}, 2'd0);
    check("R10", "busLock sel11", {1'b0, busLock}, 2'd0);

    // R2: extended mode is sticky
    step(1, 1, 2'b00, 0, 0, 0, 0, 0);
    check("R2", "extMode set with reset strobe", {1'b0, extMode}, 2'd1);
    step(0, 1, 2'b00, 0, 0, 0, 0, 0);
    check("R2", "extMode after reset-mode", {1'b0, extMode}, 2'd1);

    // Random phase
    for (int i = 0; i < 600; i++) begin
      logic req;
      req = ($urandom_range(0, 3) == 0) ? ~busReq : busReq;
      step($urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0, 2'($urandom_range(0, 3)),
           $urandom_range(0, 4) == 0, $urandom_range(0, 4) == 0, $urandom_range(0, 4) == 0,
           2'($urandom_range(0, 3)), req);
    end

    // R1: asynchronous reset in the middle of the run
    rstN = 1'b0;
    #1;
    check("R1", "extMode after reset", {1'b0, extMode}, 2'd0);
    check("R1", "busGrant after reset", {1'b0, busGrant}, 2'd0);
    finishRun();
  end
endmodule